// File: doc/BRIEF.md
# Sleep Timer Input Capture Unit

This block takes a snapshot of a free-running 24-bit low-frequency timer when a chosen input pin shows an edge. A 2-bit select field picks one of three pins, or turns capture off. Each pin has its own polarity setting that picks the rising or the falling edge. A qualifying edge arms the unit. The count is then latched on the next rising edge of the slow timer clock, and that edge must come strictly after the cycle in which the pin edge was seen. The slow clock reaches the block only as a level, sampled in the fast clock domain.

When the latch happens, a valid flag is set and a one-cycle interrupt pulse goes to the pin interrupt logic on the bit of the selected pin. While the flag is set, the unit takes no further snapshots. Software reads the value and then clears the flag. Moving from one pin to another needs two writes: the off code first, then the new pin. The safe point for the off write is while the slow clock level is high.

Top module: `slp_capture_unit`

## Requirements
- R1: After reset the select field holds 3 (capture off), the valid flag is 0, the capture value is 0 and no interrupt bit is set.
- R2: With select code s in 0..2, a qualifying edge on pin s arms the unit. The count present in the cycle of the first later slow-clock rising edge is latched into the capture value. A pin edge counts as qualifying when it is rising if the pin's polarity bit is 0, and falling if that bit is 1.
- R3: On a capture, the valid flag becomes 1. In the same cycle, pin_irq pulses for exactly one cycle on bit s only.
- R4: While the valid flag is 1, pin edges arm nothing and the capture value does not change.
- R5: A write to address 1 with data bit 0 equal to 0 clears the valid flag. A write to address 1 with data bit 0 equal to 1 leaves the flag unchanged.
- R6: A write to address 0 loads data bits [1:0] into the select field. Code 3 turns capture off: no edge arms the unit, and any pending arm is discarded without a capture.
- R7: A select write is ignored when it would move the field straight from one pin code (0..2) to a different pin code.
- R8: Edges on pins other than the selected one, and edges of the opposite polarity on the selected pin, cause no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_count | input | 24 | Running value of the low-frequency timer |
| slow_clk_lvl | input | 1 | Level of the slow timer clock, already synchronous to clk |
| pin_lvl | input | 3 | Levels of the three candidate capture pins |
| pin_fall | input | 3 | Per-pin polarity: 0 selects the rising edge, 1 the falling edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = select field, 1 = status flag |
| wr_data | input | 2 | Write data |
| cap_value | output | 24 | Captured timer value |
| cap_valid | output | 1 | Capture valid flag |
| cap_sel | output | 2 | Current select field, readable by software |
| pin_irq | output | 3 | Per-pin capture interrupt pulse |

## Verification
The bench arms the unit and then turns capture off before the next slow rising edge. A design that kept the stale arm would latch a value after the off write. It repeats edges while the valid flag is set, and a design that lacked the lock would overwrite the held value and pulse the interrupt a second time. It also tries a direct pin-to-pin select write, applies edges of the wrong polarity and edges on pins that are not selected, and writes a 1 to the status flag. Each of these exposes a unit that switches pins without the off step, decodes polarity the wrong way round, or treats any status write as a clear.

// File: rtl/slp_cap_pkg.sv
package slp_cap_pkg;

  typedef enum logic {
    REG_SELECT = 1'b0,
    REG_STATUS = 1'b1
  } reg_addr_e;

  // Qualifying edge for one pin given its polarity setting
  function automatic logic edge_seen(input logic prev, input logic cur, input logic fall);
    return fall ? (prev & ~cur) : (~prev & cur);
  endfunction

  // A select change is legal unless it hops from one live pin to another
  function automatic logic sel_change_ok(input int unsigned cur, input int unsigned nxt,
                                         input int unsigned off);
    return (cur == off) || (nxt == off) || (cur == nxt);
  endfunction

endpackage

// File: rtl/slp_edge_detect.sv
module slp_edge_detect #(
  parameter int unsigned NPIN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_lvl,
  input  logic [NPIN-1:0] pin_fall,
  input  logic            slow_lvl,
  output logic [NPIN-1:0] pin_edge,
  output logic            slow_rise
);
  import slp_cap_pkg::*;

  logic [NPIN-1:0] pin_q;
  logic            slow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      pin_q  <= pin_lvl;
      slow_q <= slow_lvl;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pin_edge[i] = edge_seen(pin_q[i], pin_lvl[i], pin_fall[i]);
  end

  assign slow_rise = slow_lvl & ~slow_q;

endmodule

// File: rtl/slp_sel_ctrl.sv
module slp_sel_ctrl #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned OFF   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [SEL_W-1:0] new_sel,
  output logic [SEL_W-1:0] sel
);
  import slp_cap_pkg::*;

  localparam logic [SEL_W-1:0] OFF_CODE = SEL_W'(OFF);

  logic accept;
  assign accept = wr_sel && sel_change_ok(int'(sel), int'(new_sel), OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel <= OFF_CODE;
    else if (accept) sel <= new_sel;
  end

  AST_NO_DIRECT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sel) != OFF_CODE) && (sel != $past(sel))) |-> (sel == OFF_CODE)); // R7

endmodule

// File: rtl/slp_cap_core.sv
module slp_cap_core #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned NPIN  = 3,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned OFF   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [NPIN-1:0]  pin_edge,
  input  logic             slow_rise,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_valid,
  output logic [NPIN-1:0]  pin_irq,
  output logic             pend
);
  localparam logic [SEL_W-1:0] OFF_CODE = SEL_W'(OFF);

  logic [NPIN-1:0] sel_hot;
  logic            sel_live;
  logic            arm_hit;
  logic            cap_fire;

  for (genvar i = 0; i < NPIN; i++) begin : g_hot
    assign sel_hot[i] = (sel == SEL_W'(i));
  end

  assign sel_live = (sel != OFF_CODE);
  assign arm_hit  = sel_live && !cap_valid && |(sel_hot & pin_edge);
  assign cap_fire = pend && slow_rise && sel_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      cap_valid <= 1'b0;
      cap_value <= '0;
      pin_irq   <= '0;
    end else begin
      pin_irq <= cap_fire ? sel_hot : '0;
      if (!sel_live || cap_fire) pend <= 1'b0;
      else if (arm_hit)          pend <= 1'b1;
      if (cap_fire) begin
        cap_valid <= 1'b1;
        cap_value <= tmr_count;
      end else if (clr_req) begin
        cap_valid <= 1'b0;
      end
    end
  end

  AST_CAP_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_valid) |-> ($past(slow_rise) && $past(pend))); // R2

  AST_IRQ_WITH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_irq) |-> ($rose(cap_valid) && ($countones(pin_irq) == 1))); // R3

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && $past(cap_valid)) |-> $stable(cap_value)); // R4

  AST_OFF_DROPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == OFF_CODE) |=> !pend); // R6

endmodule

// File: rtl/slp_capture_unit.sv
module slp_capture_unit #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned NPIN  = 3,
  localparam int unsigned SEL_W = $clog2(NPIN + 1),
  localparam int unsigned OFF   = NPIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             slow_clk_lvl,
  input  logic [NPIN-1:0]  pin_lvl,
  input  logic [NPIN-1:0]  pin_fall,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [SEL_W-1:0] wr_data,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_valid,
  output logic [SEL_W-1:0] cap_sel,
  output logic [NPIN-1:0]  pin_irq
);
  import slp_cap_pkg::*;

  logic [NPIN-1:0] pin_edge;
  logic            slow_rise;
  logic            wr_sel;
  logic            clr_req;
  logic            pend;

  assign wr_sel  = wr_en && (wr_addr == REG_SELECT);
  assign clr_req = wr_en && (wr_addr == REG_STATUS) && !wr_data[0];

  slp_edge_detect #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_fall(pin_fall),
    .slow_lvl(slow_clk_lvl), .pin_edge(pin_edge), .slow_rise(slow_rise)
  );

  slp_sel_ctrl #(.SEL_W(SEL_W), .OFF(OFF)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .new_sel(wr_data), .sel(cap_sel)
  );

  slp_cap_core #(.CNT_W(CNT_W), .NPIN(NPIN), .SEL_W(SEL_W), .OFF(OFF)) u_core (
    .clk(clk), .rst_n(rst_n), .sel(cap_sel), .pin_edge(pin_edge), .slow_rise(slow_rise),
    .tmr_count(tmr_count), .clr_req(clr_req), .cap_value(cap_value),
    .cap_valid(cap_valid), .pin_irq(pin_irq), .pend(pend)
  );

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !pend) |=> !cap_valid); // R5

endmodule

// File: tb/slp_capture_unit_bench.sv
module slp_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] tmr_count = '0;
  logic        slow_clk_lvl = 1'b0;
  logic [2:0]  pin_lvl = '0;
  logic [2:0]  pin_fall = '0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [1:0]  wr_data = '0;
  logic [23:0] cap_value;
  logic        cap_valid;
  logic [1:0]  cap_sel;
  logic [2:0]  pin_irq;

  int checks = 0;
  int fails = 0;
  int sdiv = 0;
  int irq_seen [3] = '{0, 0, 0};
  bit done = 1'b0;

  // reference model state
  int          m_sel = 3;
  bit          m_valid = 0, m_pend = 0, m_pslow = 0;
  logic [23:0] m_val = '0;
  logic [2:0]  m_irq = '0, m_ppin = '0;

  slp_capture_unit u_slp_capture_unit (
    .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count), .slow_clk_lvl(slow_clk_lvl),
    .pin_lvl(pin_lvl), .pin_fall(pin_fall), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cap_value(cap_value), .cap_valid(cap_valid),
    .cap_sel(cap_sel), .pin_irq(pin_irq)
  );

  always #2 clk = ~clk;

  // slow clock level and timer count
  always @(negedge clk) begin
    sdiv++;
    if (sdiv == 8) begin
      sdiv = 0;
      slow_clk_lvl <= ~slow_clk_lvl;
      if (!slow_clk_lvl) tmr_count <= tmr_count + 24'h00_1357;
    end
  end

  // behavioural reference model
  always @(posedge clk) begin
    bit [2:0] ev;
    bit hit, fire;
    if (!rst_n) begin
      m_sel = 3; m_valid = 0; m_val = '0; m_pend = 0; m_irq = '0;
      m_ppin = '0; m_pslow = 0;
    end else begin
      for (int i = 0; i < 3; i++)
        ev[i] = pin_fall[i] ? (m_ppin[i] && !pin_lvl[i]) : (!m_ppin[i] && pin_lvl[i]);
      hit  = (m_sel < 3) && !m_valid && ev[m_sel % 3];
      fire = m_pend && (m_sel < 3) && slow_clk_lvl && !m_pslow;
      m_irq = fire ? 3'(1 << m_sel) : 3'b000;
      if (fire) begin m_val = tmr_count; m_valid = 1; end
      else if (wr_en && wr_addr && !wr_data[0]) m_valid = 0;
      if (m_sel == 3 || fire) m_pend = 0;
      else if (hit) m_pend = 1;
      if (wr_en && !wr_addr)
        if (m_sel == 3 || wr_data == 2'd3 || int'(wr_data) == m_sel) m_sel = int'(wr_data);
      m_ppin = pin_lvl; m_pslow = slow_clk_lvl;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 value vs model", cap_value, m_val);
      chk("R4 valid vs model", cap_valid, m_valid);
      chk("R7 select vs model", cap_sel, m_sel);
      chk("R3 irq vs model", pin_irq, m_irq);
      for (int i = 0; i < 3; i++) if (pin_irq[i]) irq_seen[i]++;
    end
  end

  task automatic wr(input logic a, input logic [1:0] d);
    @(negedge clk);
    wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] held;
    wait_cyc(3);
    rst_n <= 1'b1;
    wait_cyc(2);
    chk("R1 reset select", cap_sel, 2'd3);
    chk("R1 reset valid", cap_valid, 0);
    chk("R1 reset value", cap_value, 0);
    chk("R1 reset irq", pin_irq, 0);

    wr(0, 2'd0);
    pin_lvl[0] <= 1'b1;
    wait_cyc(40);
    chk("R2 capture on pin 0", cap_valid, 1);
    chk("R3 irq pin 0 once", irq_seen[0], 1);
    held = cap_value;

    pin_lvl[0] <= 1'b0; wait_cyc(3); pin_lvl[0] <= 1'b1;
    wait_cyc(40);
    chk("R4 value held while valid", cap_value, held);
    chk("R4 no second irq", irq_seen[0], 1);

    wr(1, 2'b01); wait_cyc(2);
    chk("R5 write one keeps flag", cap_valid, 1);
    wr(1, 2'b00); wait_cyc(2);
    chk("R5 write zero clears flag", cap_valid, 0);

    wr(0, 2'd1); wait_cyc(2);
    chk("R7 direct pin switch ignored", cap_sel, 0);

    pin_lvl[1] <= 1'b1; wait_cyc(40);
    chk("R8 unselected pin ignored", cap_valid, 0);
    pin_lvl[0] <= 1'b0; wait_cyc(40);
    chk("R8 wrong polarity ignored", cap_valid, 0);

    while (!slow_clk_lvl) @(negedge clk);
    wr(0, 2'd3); wait_cyc(2);
    chk("R6 off code accepted", cap_sel, 3);
    pin_lvl[0] <= 1'b1; wait_cyc(40);
    chk("R6 no capture while off", cap_valid, 0);

    wr(0, 2'd2);
    pin_fall[2] <= 1'b1;
    pin_lvl[2] <= 1'b1; wait_cyc(40);
    chk("R8 rising ignored on falling pin", cap_valid, 0);
    pin_lvl[2] <= 1'b0; wait_cyc(40);
    chk("R2 falling capture on pin 2", cap_valid, 1);
    chk("R3 irq pin 2 once", irq_seen[2], 1);
    chk("R3 irq pin 0 unchanged", irq_seen[0], 1);

    wr(1, 2'b00);
    pin_lvl[2] <= 1'b1; wait_cyc(4);
    while (slow_clk_lvl) @(negedge clk);
    while (!slow_clk_lvl) @(negedge clk);
    pin_lvl[2] <= 1'b0;
    wait_cyc(2);
    wr(0, 2'd3);
    wait_cyc(40);
    chk("R6 pending arm discarded", cap_valid, 0);
    chk("R6 no irq after discard", irq_seen[2], 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule